// File: doc/BRIEF.md
# SPI GPIO Expander Register File

This block is the device side of a serial GPIO expander. An SPI master sends 16-bit command frames that set the mode of each pin, drive output levels, switch the expander between shutdown and normal operation, and read back register contents. The block turns that register state into parallel pad controls for each pin: an output value, an output enable and a pull-up enable. It also samples the level on each pad.

The SPI pins are sampled by a fast system clock. They pass through synchronisers and an edge detector, so `sclk` must be well below the system clock rate. A frame controller is built around three states. `ST_IDLE` waits for chip select. `ST_SHIFT` counts rising edges of the serial clock and shifts bits in. `ST_FULL` holds a complete frame until chip select is released. The transitions are as follows:
- idle→shift when chip select goes active.
- shift→full on the sixteenth rising edge.
- shift→idle when chip select is released early, which discards the frame.
- full→idle when chip select is released, which commits the frame.

The register file applies each committed frame. It also prepares the response word that the next frame shifts out.

Top module: `spi_gpio_expander`

## Requirements
- R1: After reset, every pin field reads 2'b10 (input, no pull-up), the run bit is 0, all output latches are 0, and all `pad_oe` and `pad_pu` bits are low.
- R2: A frame is 16 bits, taken MSB first on rising `sclk`. Bit 15 set means read, bits 14:8 are the address and bits 7:0 are the data. A configuration register at address 8 + (p/4) holds the 2-bit mode of pin p in bits [2*(p%4)+1 : 2*(p%4)]. The mode codes are 01 output, 10 input and 11 input with pull-up.
- R3: A write carrying 00 in a pin field leaves that pin's mode unchanged. The other fields of the same write still take effect.
- R4: Bit 0 of address 0x04 is the run bit. While it is 0, every `pad_oe` and `pad_pu` is low, but all registers can still be written and read.
- R5: The pin register at 0x20 + p sets the output latch of pin p from data bit 0 on write. On read it returns the sampled `pad_in` level of pin p in bit 0, with bits 7:1 zero. Pin p maps to pad index p−4, and pins 4 to 31 exist.
- R6: The frame after a read shifts out {8'h00, register value} on `dout`, MSB first. The frame after a write shifts out 16'h0000. Between frames and after reset, the pending response is 16'h0000.
- R7: A frame cut short by chip select rising before 16 rising edges changes no register and no pending response.
- R8: Unmapped addresses ignore writes and read as 8'h00. These include 0x08, 0x20 to 0x23, 0x05 and anything above 0x3F.
- R9: With the run bit at 1, `pad_oe[i]` is high exactly when pin i+4 has mode 01, and `pad_pu[i]` is high exactly when it has mode 11. `pad_out[i]` always equals the latch of pin i+4.
- R10: `dout` changes only after a falling `sclk` edge within a frame, so it is stable at each rising edge. It is 0 while chip select is inactive.
- R11: Rising edges beyond the sixteenth in one frame are ignored, and the first 16 bits are committed when chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| din | input | 1 | SPI data from the master |
| dout | output | 1 | SPI data to the master |
| pad_in | input | NUM_PINS | Sampled level of each pad |
| pad_out | output | NUM_PINS | Output value of each pad |
| pad_oe | output | NUM_PINS | Output enable of each pad |
| pad_pu | output | NUM_PINS | Pull-up enable of each pad |

## Verification
The hardest cases to reach from the ports are a partly shifted frame abandoned in `ST_SHIFT` and an over-long frame parked in `ST_FULL`. The bench produces both with its serial task, which takes an arbitrary bit count per frame. The next frame's response word then shows whether the pending response or any register was disturbed. Rejected 00 mode fields are mixed with legal fields in the same write, so a preserved field and an updated neighbour are observed together. A behavioural model checks the pad vectors on every settled clock, both in shutdown and in normal operation.

// File: rtl/spi_gpio_pkg.sv
package spi_gpio_pkg;
    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;

    localparam logic [ADDR_W-1:0] ADDR_RUN      = 7'h04;
    localparam logic [ADDR_W-1:0] ADDR_CFG_BASE = 7'h08;
    localparam logic [ADDR_W-1:0] ADDR_PIN_BASE = 7'h20;

    localparam logic [1:0] MODE_BAD   = 2'b00;
    localparam logic [1:0] MODE_OUT   = 2'b01;
    localparam logic [1:0] MODE_IN    = 2'b10;
    localparam logic [1:0] MODE_IN_PU = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL
    } frame_state_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic din_s
);
    logic [STAGES-1:0] sclk_sr;
    logic [STAGES-1:0] cs_sr;
    logic [STAGES-1:0] din_sr;
    logic              sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sr <= '0;
            cs_sr   <= '1;
            din_sr  <= '0;
            sclk_q  <= 1'b0;
        end else begin
            sclk_sr <= {sclk_sr[STAGES-2:0], sclk};
            cs_sr   <= {cs_sr[STAGES-2:0], cs_n};
            din_sr  <= {din_sr[STAGES-2:0], din};
            sclk_q  <= sclk_sr[STAGES-1];
        end
    end

    assign sclk_rise = sclk_sr[STAGES-1] & ~sclk_q;
    assign sclk_fall = ~sclk_sr[STAGES-1] & sclk_q;
    assign cs_active = ~cs_sr[STAGES-1];
    assign din_s     = din_sr[STAGES-1];
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_gpio_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic                  cs_active,
    input  logic                  din_s,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  commit,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  dout
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    frame_state_e    state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [FRAME_BITS-1:0] tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_active) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (!cs_active)
                    state_nx = ST_IDLE;
                else if (sclk_rise && cnt == CNT_W'(FRAME_BITS - 1))
                    state_nx = ST_FULL;
            end
            ST_FULL:  if (!cs_active) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rx_word <= '0;
            tx_sh   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (cs_active) tx_sh <= tx_word;
                end
                ST_SHIFT: begin
                    if (cs_active && sclk_rise) begin
                        rx_word <= {rx_word[FRAME_BITS-2:0], din_s};
                        cnt     <= cnt + 1'b1;
                    end
                    if (cs_active && sclk_fall && cnt != '0)
                        tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                end
                ST_FULL: ;
                default: cnt <= '0;
            endcase
        end
    end

    assign commit = (state == ST_FULL) && !cs_active;
    assign dout   = (state != ST_IDLE) ? tx_sh[FRAME_BITS-1] : 1'b0;

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_BITS));

    // R7
    commit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> cnt == CNT_W'(FRAME_BITS));

    // R10
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && cs_active && !sclk_fall) |=> $stable(dout));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import spi_gpio_pkg::*;
#(
    parameter int NUM_PINS  = 28,
    parameter int FIRST_PIN = 4,
    parameter int SYNC_LEN  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [FRAME_W-1:0]  frame,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [FRAME_W-1:0]  tx_word
);
    logic                is_read;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
    logic [DATA_W-1:0]   rd_data;
    logic [1:0]          modes [NUM_PINS];
    logic [NUM_PINS-1:0] latch;
    logic                run;
    logic [NUM_PINS-1:0] in_sync [SYNC_LEN];

    assign is_read = frame[FRAME_W-1];
    assign addr    = frame[FRAME_W-2 -: ADDR_W];
    assign data    = frame[DATA_W-1:0];

    function automatic logic [ADDR_W-1:0] cfg_addr(input int i);
        return ADDR_CFG_BASE + ADDR_W'((FIRST_PIN + i) >> 2);
    endfunction

    function automatic logic [ADDR_W-1:0] pin_addr(input int i);
        return ADDR_PIN_BASE + ADDR_W'(FIRST_PIN + i);
    endfunction

    function automatic int fld(input int i);
        return ((FIRST_PIN + i) % 4) * 2;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_LEN; s++) in_sync[s] <= '0;
        end else begin
            in_sync[0] <= pad_in;
            for (int s = 1; s < SYNC_LEN; s++) in_sync[s] <= in_sync[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run   <= 1'b0;
            latch <= '0;
            for (int i = 0; i < NUM_PINS; i++) modes[i] <= MODE_IN;
        end else if (commit && !is_read) begin
            if (addr == ADDR_RUN) run <= data[0];
            for (int i = 0; i < NUM_PINS; i++) begin
                if (addr == cfg_addr(i) && data[fld(i) +: 2] != MODE_BAD)
                    modes[i] <= data[fld(i) +: 2];
                if (addr == pin_addr(i))
                    latch[i] <= data[0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_RUN) rd_data[0] = run;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (addr == cfg_addr(i)) rd_data[fld(i) +: 2] = modes[i];
            if (addr == pin_addr(i)) rd_data[0] = in_sync[SYNC_LEN-1][i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tx_word <= '0;
        else if (commit) tx_word <= is_read ? {{(FRAME_W-DATA_W){1'b0}}, rd_data} : '0;
    end

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            pad_out[i] = latch[i];
            pad_oe[i]  = run && (modes[i] == MODE_OUT);
            pad_pu[i]  = run && (modes[i] == MODE_IN_PU);
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_mode_chk
        // R3
        mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            modes[g] != MODE_BAD);
    end

    // R9
    oe_pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);

    // R4
    shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !is_read && addr == ADDR_RUN && !data[0])
            |=> (pad_oe == '0 && pad_pu == '0));
endmodule

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander
    import spi_gpio_pkg::*;
#(
    parameter int NUM_PINS  = 28,
    parameter int FIRST_PIN = 4,
    parameter int SYNC_LEN  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                din,
    output logic                dout,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu
);
    logic               sclk_rise, sclk_fall, cs_active, din_s;
    logic               commit;
    logic [FRAME_W-1:0] rx_word, tx_word;

    spi_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .din_s(din_s)
    );

    spi_frame_fsm #(.FRAME_BITS(FRAME_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .din_s(din_s), .tx_word(tx_word),
        .commit(commit), .rx_word(rx_word), .dout(dout)
    );

    gpio_regs #(.NUM_PINS(NUM_PINS), .FIRST_PIN(FIRST_PIN), .SYNC_LEN(SYNC_LEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .frame(rx_word),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .tx_word(tx_word)
    );
endmodule

// File: tb/spi_gpio_expander_test.sv
module spi_gpio_expander_test;
    localparam int NP = 28;
    localparam int HB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
    logic dout;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pu;

    int checks = 0, fails = 0;
    bit settled = 1'b0;
    bit done = 1'b0;

    int       mode_m [32];
    bit       latch_m [32];
    bit       run_m;
    logic [15:0] pend_m;

    always #5 clk = ~clk;

    spi_gpio_expander uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mread(input logic [6:0] a);
        logic [7:0] r = 8'h00;
        if (a == 7'h04) r[0] = run_m;
        else if (a >= 7'h09 && a <= 7'h0F)
            for (int j = 0; j < 4; j++) r[2*j +: 2] = 2'(mode_m[(a - 8) * 4 + j]);
        else if (a >= 7'h24 && a <= 7'h3F) r[0] = pad_in[a - 7'h24];
        return r;
    endfunction

    task automatic mwrite(input logic [6:0] a, input logic [7:0] d);
        if (a == 7'h04) run_m = d[0];
        else if (a >= 7'h09 && a <= 7'h0F) begin
            for (int j = 0; j < 4; j++)
                if (d[2*j +: 2] != 2'b00) mode_m[(a - 8) * 4 + j] = d[2*j +: 2];
        end else if (a >= 7'h24 && a <= 7'h3F) latch_m[a - 7'h20] = d[0];
    endtask

    // per-clock comparison of pad controls (R9, R4)
    always @(negedge clk) begin
        if (settled) begin
            logic [NP-1:0] eo, ep, el;
            for (int i = 0; i < NP; i++) begin
                el[i] = latch_m[i+4];
                eo[i] = run_m && mode_m[i+4] == 1;
                ep[i] = run_m && mode_m[i+4] == 3;
            end
            chk(pad_oe == eo && pad_pu == ep && pad_out == el, "R9 pads",
                {pad_oe, pad_pu, pad_out}, {eo, ep, el});
        end
    end

    task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] rx);
        logic [15:0] exp_rx = pend_m;
        settled = 1'b0;
        rx = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HB) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            din = (b < 16) ? w[15-b] : 1'b0;
            repeat (HB) @(negedge clk);
            if (b < 16) rx = {rx[14:0], dout};
            sclk = 1'b1;
            repeat (HB) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HB) @(negedge clk);
        cs_n = 1'b1;
        repeat (HB) @(negedge clk);
        chk(dout == 1'b0, "R10 idle dout", dout, 0);
        if (nbits >= 16) begin
            // R6: response word of this frame came from the previous one
            chk(rx == exp_rx, "R6 response", rx, exp_rx);
            if (w[15]) pend_m = {8'h00, mread(w[14:8])};
            else begin
                pend_m = 16'h0000;
                mwrite(w[14:8], w[7:0]);
            end
        end
        repeat (2) @(negedge clk);
        settled = 1'b1;
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [15:0] rx;
        xfer({1'b0, a, d}, 16, rx);
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] exp, input string req);
        logic [15:0] rx;
        xfer({1'b1, a, 8'h00}, 16, rx);
        xfer({1'b1, 7'h00, 8'h00}, 16, rx);
        chk(rx == {8'h00, exp}, req, rx, {8'h00, exp});
    endtask

    initial begin
        logic [15:0] rx;
        for (int p = 0; p < 32; p++) begin mode_m[p] = 2; latch_m[p] = 0; end
        run_m = 0; pend_m = 16'h0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(pad_oe == '0 && pad_pu == '0 && pad_out == '0, "R1 reset pads",
            {pad_oe, pad_pu, pad_out}, 0);
        chk(dout == 1'b0, "R10 reset dout", dout, 0);
        settled = 1'b1;
        rd(7'h09, 8'hAA, "R1 cfg reset");
        rd(7'h0F, 8'hAA, "R1 last cfg reset");
        rd(7'h04, 8'h00, "R1 run reset");

        // R4 run on
        wr(7'h04, 8'h01);
        rd(7'h04, 8'h01, "R4 run readback");

        // R2 mode fields: pin4=01 pin5=01 pin6=10 pin7=11
        wr(7'h09, 8'hE5);
        rd(7'h09, 8'hE5, "R2 cfg readback");
        chk(pad_oe[1:0] == 2'b11 && pad_pu[3] == 1'b1, "R9 pin4..7 pads",
            {pad_oe[3:0], pad_pu[3:0]}, 8'h38);

        // R3 00 fields rejected
        wr(7'h09, 8'h00);
        rd(7'h09, 8'hE5, "R3 all-zero write kept");
        wr(7'h0A, 8'h13);
        rd(7'h0A, 8'h9B, "R3 mixed field write");

        // R5 pin registers
        wr(7'h24, 8'h01);
        chk(pad_out[0] == 1'b1, "R5 latch set", pad_out[0], 1);
        wr(7'h25, 8'hFE);
        chk(pad_out[1] == 1'b0, "R5 latch uses bit0", pad_out[1], 0);
        pad_in = 28'h8000004;
        repeat (6) @(negedge clk);
        rd(7'h26, 8'h01, "R5 input high");
        rd(7'h27, 8'h00, "R5 input low");
        rd(7'h3F, 8'h01, "R5 last pin");

        // R6 frame after a write returns zero
        wr(7'h3F, 8'h01);
        xfer({1'b1, 7'h00, 8'h00}, 16, rx);
        chk(rx == 16'h0000, "R6 after write", rx, 0);

        // R7 short frames discarded
        xfer({1'b0, 7'h04, 8'h00}, 10, rx);
        rd(7'h04, 8'h01, "R7 short write dropped");
        xfer({1'b1, 7'h09, 8'h00}, 16, rx);
        xfer({1'b0, 7'h09, 8'h55}, 15, rx);
        xfer({1'b1, 7'h00, 8'h00}, 16, rx);
        chk(rx == 16'h00E5, "R7 pending kept", rx, 16'h00E5);

        // R8 unmapped
        wr(7'h08, 8'h55);
        wr(7'h20, 8'h01);
        wr(7'h7F, 8'hFF);
        rd(7'h08, 8'h00, "R8 addr 08");
        rd(7'h20, 8'h00, "R8 addr 20");
        rd(7'h05, 8'h00, "R8 addr 05");
        rd(7'h7F, 8'h00, "R8 addr 7F");
        rd(7'h09, 8'hE5, "R8 cfg untouched");

        // R4 shutdown
        wr(7'h04, 8'h00);
        chk(pad_oe == '0 && pad_pu == '0, "R4 shutdown pads", {pad_oe, pad_pu}, 0);
        wr(7'h0B, 8'h57);
        rd(7'h0B, 8'h57, "R4 write in shutdown");
        wr(7'h2C, 8'h01);
        chk(pad_out[8] == 1'b1, "R4 latch in shutdown", pad_out[8], 1);
        wr(7'h04, 8'h01);
        chk(pad_oe[8] == 1'b0 && pad_pu[8] == 1'b1, "R4 run restored",
            {pad_oe[8], pad_pu[8]}, 2'b01);

        // R11 extra clocks
        xfer({1'b0, 7'h0F, 8'h55}, 19, rx);
        settled = 1'b0;
        pend_m = 16'h0000;
        mwrite(7'h0F, 8'h55);
        repeat (2) @(negedge clk);
        settled = 1'b1;
        rd(7'h0F, 8'h55, "R11 long frame committed");
        chk(pad_oe[27:24] == 4'hF, "R11 pads", pad_oe[27:24], 4'hF);

        // all pins output with alternating latches
        for (int k = 9; k <= 14; k++) wr(7'(k), 8'h55);
        for (int p = 4; p < 32; p++) wr(7'(32 + p), 8'(p & 1));
        chk(pad_oe == '1, "R9 all outputs", pad_oe, 28'hFFFFFFF);
        chk(pad_out == 28'hAAAAAAA, "R5 alternating latches", pad_out, 28'hAAAAAAA);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule